// File: doc/BRIEF.md
# Scan Data Register Bank with Multicast Group Match

This block holds the data registers behind the primary test port of a device that shares a scan chain with other devices and is addressed over it. The test-access controller outside the block drives one-cycle state strobes: test-logic-reset, capture-DR, shift-DR, update-DR and capture-IR. It also drives a 2-bit register select that comes from the instruction decode. The block shifts the selected register between `tdi` and `tdo`. It keeps the identification and user-code contents fixed, and it stores a writable 2-bit multicast group.

The group value places the device in one of four multicast groups. An 8-bit device address presented on `dev_addr` raises `mcast_hit` when its middle four bits are all ones and its two low bits equal the stored group. The two top bits are ignored, so the addresses take the form xx1111gg. The group register has its own shift stage. A shift that is abandoned before update-DR therefore never disturbs the stored group.

All ports are plain control and data pins. Serial data moves one bit per TCK cycle while shift-DR is high, and there is no handshake or back-pressure on any of them.

Top module: `scan_dr_bank`

## Requirements
- R1: With select 00 (one-bit bypass stage), capture-DR loads the stage with 0. Each shift-DR cycle moves `tdi` into the stage, so `tdo` repeats `tdi` one shift later.
- R2: `group_id` takes the group shift stage value only on an update-DR cycle while select is 11. On every other cycle it holds.
- R3: With select 11, capture-DR loads the 2-bit group shift stage with `group_id`. Shift-DR then presents the bits LSB first on `tdo` while taking new bits from `tdi` at the MSB end.
- R4: `group_id` is 00 while `trst_n` is low (asynchronous) and on the cycle after any test-logic-reset strobe.
- R5: The 32-bit identification stage (select 01) reloads 0x0000836F on test-logic-reset, on capture-IR whatever the select, and on capture-DR with select 01. Shifting presents it LSB first, so the first 12 bits are 0x36F.
- R6: The 8-bit user-code stage (select 10) accepts `tdi` while shifting, but every capture-DR loads it with zeros. A read after any write therefore returns eight zeros.
- R7: `mcast_hit` is high, in the same cycle, exactly when `dev_addr[5:2]` is 1111 and `dev_addr[1:0]` equals `group_id`. Bits [7:6] are ignored.
- R8: `tdo` changes only on the falling edge of `tck`. After each falling edge it shows bit 0 of the stage named by the select.
- R9: A group shift that is not followed by update-DR with select 11 leaves `group_id` unchanged.
- R10: In one cycle, test-logic-reset overrides capture, shift and update. Capture (DR, or IR for the identification stage) overrides shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | Test-logic-reset state strobe |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| capture_ir | input | 1 | Capture-IR state strobe |
| dr_sel | input | 2 | Register select: 00 bypass, 01 identification, 10 user code, 11 group |
| tdi | input | 1 | Serial data in |
| dev_addr | input | 8 | Device address compared against the multicast pattern |
| tdo | output | 1 | Serial data out, retimed on the falling edge |
| group_id | output | 2 | Stored multicast group |
| mcast_hit | output | 1 | Address matches this device's multicast group |

## Verification
Two pairs of functions can land in the same cycle, and the bench drives both.

The first pair is a group write and the address match. The bench holds `dev_addr` on a matching pattern across the update-DR cycle, and `mcast_hit` must follow the new group on the very next sample. The second pair is test-logic-reset arriving together with update-DR or capture-DR. Those strobes are raised in one cycle with the group selected, and the reference model's priority of reset over update, and of capture over shift, decides the expected group, `tdo` and hit on every clock.

// File: rtl/scan_dr_pkg.sv
package scan_dr_pkg;
  typedef enum logic [1:0] {
    SEL_BYPASS = 2'b00,
    SEL_IDENT  = 2'b01,
    SEL_USER   = 2'b10,
    SEL_GROUP  = 2'b11
  } dr_sel_e;

  localparam int          TAG_W      = 4;
  localparam logic [31:0] ID_DEFAULT = 32'h0000_836F;
endpackage

// File: rtl/dr_stage.sv
module dr_stage #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt_shift;

  generate
    if (W == 1) begin : g_single
      assign nxt_shift = sin;
    end else begin : g_multi
      assign nxt_shift = {sin, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    q <= RST_VAL;
    else if (load)  q <= load_val;
    else if (shift) q <= nxt_shift;
  end
endmodule

// File: rtl/mcast_group.sv
module mcast_group import scan_dr_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int GRP_W  = 2
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              clear,
  input  logic              commit,
  input  logic [GRP_W-1:0]  new_grp,
  input  logic [ADDR_W-1:0] addr,
  output logic [GRP_W-1:0]  grp,
  output logic              hit
);
  localparam int              CARE_W    = GRP_W + TAG_W;
  localparam logic [ADDR_W-1:0] CARE_MASK = ADDR_W'({CARE_W{1'b1}});
  localparam logic [ADDR_W-1:0] TAG_PAT   = ADDR_W'({{TAG_W{1'b1}}, {GRP_W{1'b0}}});

  logic [ADDR_W-1:0] want;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     grp <= '0;
    else if (clear)  grp <= '0;
    else if (commit) grp <= new_grp;
  end

  assign want = TAG_PAT | ADDR_W'(grp);
  assign hit  = ((addr & CARE_MASK) == want);
endmodule

// File: rtl/tdo_retime.sv
module tdo_retime #(
  parameter int N_SRC = 4,
  parameter int SEL_W = $clog2(N_SRC)
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [N_SRC-1:0] lsb,
  input  logic [SEL_W-1:0] sel,
  output logic             tdo
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= lsb[sel];
  end
endmodule

// File: rtl/scan_dr_bank.sv
module scan_dr_bank import scan_dr_pkg::*; #(
  parameter int              ADDR_W   = 8,
  parameter int              GRP_W    = 2,
  parameter int              ID_W     = 32,
  parameter int              USER_W   = 8,
  parameter logic [ID_W-1:0] ID_VALUE = ID_W'(ID_DEFAULT)
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tlr,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              capture_ir,
  input  logic [1:0]        dr_sel,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              tdo,
  output logic [GRP_W-1:0]  group_id,
  output logic              mcast_hit
);
  localparam int N_SRC = 4;

  dr_sel_e sel;
  logic sel_byp, sel_id, sel_usr, sel_grp;
  logic [0:0]        byp_q;
  logic [ID_W-1:0]   id_q;
  logic [USER_W-1:0] usr_q;
  logic [GRP_W-1:0]  gs_q;
  logic [GRP_W-1:0]  gs_load;
  logic [N_SRC-1:0]  lsb_bus;

  assign sel     = dr_sel_e'(dr_sel);
  assign sel_byp = (sel == SEL_BYPASS);
  assign sel_id  = (sel == SEL_IDENT);
  assign sel_usr = (sel == SEL_USER);
  assign sel_grp = (sel == SEL_GROUP);

  // Reset strobe first, then capture, then shift.
  dr_stage #(.W(1), .RST_VAL(1'b0)) u_byp (
    .tck(tck), .trst_n(trst_n),
    .load(tlr | (capture_dr & sel_byp)), .load_val(1'b0),
    .shift(shift_dr & sel_byp), .sin(tdi), .q(byp_q)
  );

  dr_stage #(.W(ID_W), .RST_VAL(ID_VALUE)) u_id (
    .tck(tck), .trst_n(trst_n),
    .load(tlr | capture_ir | (capture_dr & sel_id)), .load_val(ID_VALUE),
    .shift(shift_dr & sel_id), .sin(tdi), .q(id_q)
  );

  dr_stage #(.W(USER_W), .RST_VAL('0)) u_usr (
    .tck(tck), .trst_n(trst_n),
    .load(tlr | (capture_dr & sel_usr)), .load_val('0),
    .shift(shift_dr & sel_usr), .sin(tdi), .q(usr_q)
  );

  assign gs_load = tlr ? '0 : group_id;

  dr_stage #(.W(GRP_W), .RST_VAL('0)) u_gs (
    .tck(tck), .trst_n(trst_n),
    .load(tlr | (capture_dr & sel_grp)), .load_val(gs_load),
    .shift(shift_dr & sel_grp), .sin(tdi), .q(gs_q)
  );

  mcast_group #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_grp (
    .tck(tck), .trst_n(trst_n),
    .clear(tlr), .commit(update_dr & sel_grp), .new_grp(gs_q),
    .addr(dev_addr), .grp(group_id), .hit(mcast_hit)
  );

  assign lsb_bus[SEL_BYPASS] = byp_q[0];
  assign lsb_bus[SEL_IDENT]  = id_q[0];
  assign lsb_bus[SEL_USER]   = usr_q[0];
  assign lsb_bus[SEL_GROUP]  = gs_q[0];

  tdo_retime #(.N_SRC(N_SRC)) u_tdo (
    .tck(tck), .trst_n(trst_n), .lsb(lsb_bus), .sel(dr_sel), .tdo(tdo)
  );
endmodule

// File: rtl/scan_dr_bank_chk.sv
module scan_dr_bank_chk #(
  parameter int              ADDR_W   = 8,
  parameter int              GRP_W    = 2,
  parameter int              ID_W     = 32,
  parameter int              USER_W   = 8,
  parameter logic [ID_W-1:0] ID_VALUE = '0
) (
  input logic              tck,
  input logic              trst_n,
  input logic              tlr,
  input logic              capture_dr,
  input logic              update_dr,
  input logic              capture_ir,
  input logic [1:0]        dr_sel,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [GRP_W-1:0]  group_id,
  input logic              mcast_hit,
  input logic [0:0]        byp_q,
  input logic [ID_W-1:0]   id_q,
  input logic [USER_W-1:0] usr_q
);
  // R1
  r1_bypass_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && dr_sel == 2'b00) |=> (byp_q == 1'b0));

  // R2
  r2_grp_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!tlr && !(update_dr && dr_sel == 2'b11)) |=> $stable(group_id));

  // R4
  r4_tlr_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> (group_id == '0));

  // R5
  r5_id_reload_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_ir || tlr) |=> (id_q == ID_VALUE));

  // R6
  r6_user_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && dr_sel == 2'b10) |=> (usr_q == '0));

  // R7
  r7_no_tag_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (dev_addr[GRP_W+3:GRP_W] != 4'hF) |-> !mcast_hit);

  // R7
  r7_hit_grp_chk: assert property (@(posedge tck) disable iff (!trst_n)
    mcast_hit |-> (dev_addr[GRP_W-1:0] == group_id));
endmodule

bind scan_dr_bank scan_dr_bank_chk #(
  .ADDR_W(ADDR_W), .GRP_W(GRP_W), .ID_W(ID_W), .USER_W(USER_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
  .update_dr(update_dr), .capture_ir(capture_ir), .dr_sel(dr_sel),
  .dev_addr(dev_addr), .group_id(group_id), .mcast_hit(mcast_hit),
  .byp_q(byp_q), .id_q(id_q), .usr_q(usr_q)
);

// File: tb/test_scan_dr_bank.sv
`timescale 1ns/100ps
module test_scan_dr_bank;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tlr = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, capture_ir = 0;
  logic [1:0] dr_sel = 2'b00;
  logic       tdi = 0;
  logic [7:0] dev_addr = 8'h00;
  logic       tdo;
  logic [1:0] group_id;
  logic       mcast_hit;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic        m_byp;
  logic [31:0] m_id;
  logic [7:0]  m_usr;
  logic [1:0]  m_gs;
  logic [1:0]  m_grp;
  logic        m_tdo;
  logic [7:0]  cur_addr = 8'h00;
  localparam logic [31:0] ID_EXP = 32'h0000_836F;

  always #4 tck = ~tck;

  scan_dr_bank i_scan_dr_bank (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .capture_ir(capture_ir),
    .dr_sel(dr_sel), .tdi(tdi), .dev_addr(dev_addr),
    .tdo(tdo), .group_id(group_id), .mcast_hit(mcast_hit)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic model_hit(input logic [7:0] a, input logic [1:0] g);
    return (a[5:2] == 4'b1111) && (a[1:0] == g);
  endfunction

  function automatic string tdo_tag(input logic [1:0] s);
    case (s)
      2'b00:   return "R1/R8 tdo bypass";
      2'b01:   return "R5/R8 tdo ident";
      2'b10:   return "R6/R8 tdo user";
      default: return "R3/R8 tdo group";
    endcase
  endfunction

  task automatic model_reset();
    m_byp = 0; m_id = ID_EXP; m_usr = 0; m_gs = 0; m_grp = 0; m_tdo = 0;
  endtask

  task automatic compare_all();
    check(tdo_tag(dr_sel), tdo, m_tdo);
    check("R2/R4/R9 group_id", group_id, m_grp);
    check("R7 mcast_hit", mcast_hit, model_hit(dev_addr, m_grp));
  endtask

  // Called just before a rising edge; ends just before the next one.
  task automatic step(input bit t, input bit cd, input bit sd, input bit ud, input bit ci,
                      input logic [1:0] s, input bit d);
    tlr = t; capture_dr = cd; shift_dr = sd; update_dr = ud; capture_ir = ci;
    dr_sel = s; tdi = d; dev_addr = cur_addr;
    @(posedge tck);
    if (t) begin
      m_byp = 0; m_id = ID_EXP; m_usr = 0; m_gs = 0; m_grp = 0;
    end else begin
      if (ud && s == 2'b11) m_grp = m_gs;
      if (ci || (cd && s == 2'b01)) m_id = ID_EXP;
      else if (sd && s == 2'b01) m_id = (m_id >> 1) | (32'(d) << 31);
      if (cd) begin
        if (s == 2'b00) m_byp = 0;
        if (s == 2'b10) m_usr = 0;
        if (s == 2'b11) m_gs = m_grp;
      end else if (sd) begin
        if (s == 2'b00) m_byp = d;
        if (s == 2'b10) m_usr = (m_usr >> 1) | (8'(d) << 7);
        if (s == 2'b11) m_gs = (m_gs >> 1) | (2'(d) << 1);
      end
    end
    #1;
    check("R8 tdo held across rising edge", tdo, m_tdo);
    @(negedge tck);
    case (s)
      2'b00:   m_tdo = m_byp;
      2'b01:   m_tdo = m_id[0];
      2'b10:   m_tdo = m_usr[0];
      default: m_tdo = m_gs[0];
    endcase
    #3;
    compare_all();
  endtask

  task automatic idle(input logic [1:0] s, input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, s, 0);
  endtask

  task automatic scan(input logic [1:0] s, input int n, input logic [31:0] data, input bit upd);
    step(0, 1, 0, 0, 0, s, 0);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, s, data[i]);
    if (upd) step(0, 0, 0, 1, 0, s, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    #3;
    // reset state
    check("R4 reset group_id", group_id, 2'b00);
    check("R8 reset tdo", tdo, 1'b0);
    check("R7 reset hit (addr 00)", mcast_hit, 1'b0);
    @(negedge tck); @(negedge tck); #3;
    trst_n = 1'b1;
    step(1, 0, 0, 0, 0, 2'b00, 0);

    // R3 R2: write group 2 while address matches group 2
    cur_addr = 8'h3E;
    scan(2'b11, 2, 32'h2, 1);
    check("R2 group written", group_id, 2'b10);
    check("R7 hit for 0x3E", mcast_hit, 1'b1);
    cur_addr = 8'hFE; idle(2'b11, 1);
    check("R7 hit ignores top bits 0xFE", mcast_hit, 1'b1);
    cur_addr = 8'h3D; idle(2'b11, 1);
    check("R7 miss other group 0x3D", mcast_hit, 1'b0);
    cur_addr = 8'h2E; idle(2'b11, 1);
    check("R7 miss broken tag 0x2E", mcast_hit, 1'b0);

    // R3 readback, R9 aborted shift
    cur_addr = 8'h3E;
    scan(2'b11, 2, 32'h1, 0);
    idle(2'b00, 2);
    check("R9 aborted shift keeps group", group_id, 2'b10);
    // R2 update with another select
    step(0, 0, 0, 1, 0, 2'b00, 0);
    check("R2 update while bypass selected", group_id, 2'b10);
    scan(2'b11, 2, 32'h0, 0);

    // R5 identification read, then corrupt and reload via capture-IR
    scan(2'b01, 32, 32'hFFFF_FFFF, 0);
    step(0, 0, 0, 0, 1, 2'b01, 0);
    for (int i = 0; i < 32; i++) step(0, 0, 1, 0, 0, 2'b01, 1);
    scan(2'b01, 32, 32'h0, 0);

    // R1 bypass pattern
    scan(2'b00, 12, 32'hA5C, 0);

    // R6 user code: write ones, then read
    scan(2'b10, 8, 32'hFF, 1);
    scan(2'b10, 8, 32'h00, 0);

    // R10: capture and shift in one cycle on group register
    cur_addr = 8'h3F;
    scan(2'b11, 2, 32'h3, 1);
    check("R2 group 3", group_id, 2'b11);
    step(0, 1, 1, 0, 0, 2'b11, 0);
    step(0, 0, 1, 0, 0, 2'b11, 0);
    // R10: reset strobe with update in the same cycle
    step(0, 0, 1, 0, 0, 2'b11, 1);
    step(1, 0, 0, 1, 0, 2'b11, 0);
    check("R10 reset beats update", group_id, 2'b00);
    check("R7 hit after clear 0x3F", mcast_hit, 1'b0);
    // R10 capture-IR with shift on identification
    step(0, 0, 1, 0, 1, 2'b01, 1);

    // R4 asynchronous reset in mid-run
    cur_addr = 8'h3D;
    scan(2'b11, 2, 32'h1, 1);
    check("R2 group 1", group_id, 2'b01);
    trst_n = 1'b0;
    #1;
    model_reset();
    check("R4 async reset group", group_id, 2'b00);
    check("R8 async reset tdo", tdo, 1'b0);
    @(negedge tck); #3;
    trst_n = 1'b1;
    idle(2'b01, 2);
    scan(2'b01, 12, 32'h0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule